// File: doc/BRIEF.md
# Flash Power-Up Write Inhibit Gate

This block sits between the instruction decoder of a serial flash memory and the rest of its control logic. It keeps the core out of harm's way while the supply is ramping up or collapsing. Two digital flags come from the analog supply monitors. One says the supply is above the write-inhibit threshold. The other says the supply has reached its minimum operating level. While the first flag is low, or the external active-low reset is low, the block holds the core in reset and accepts no instruction at all.

Once the block has left the held state, two down-counters run on their own. The write timer starts when the inhibit flag is up. The read timer starts only while the minimum-level flag is also up. Read-class instructions are let through as soon as the read timer expires. Write-class instructions also need the write timer to have expired, so writes are released at the later of the two points. Each decoded opcode, strobed while the chip is selected, gets exactly one verdict one cycle later: a forward pulse or an ignored pulse. A blocked instruction has no other effect.

On the first cycle after the held state ends, a clear pulse tells the status and lock logic to return to its power-up values: standby rather than deep power-down, write-enable latch and write-in-progress both 0, and every lock register's write-lock and lock-down bits both 0.

Top module: `flash_pwrup_gate`

## Requirements
- R1: `held_rst` is 1 whenever `rst_n` is 0 or `sup_inhibit_ok` is 0. After `rst_n` rises, `held_rst` stays 1 for two more rising clock edges. While `held_rst` is 1, `rd_en` and `wr_en` are both 0.
- R2: While `held_rst` is 1 at a clock edge, no `op_accept` or `op_ignored` pulse follows that edge.
- R3: Write-class opcodes are ignored until `WR_DLY` consecutive edges have passed without `held_rst`. A write-class opcode arriving while `wr_en` is 0 (and the gate is not held) yields an `op_ignored` pulse.
- R4: `rd_en` is 1 only once `RD_DLY` consecutive edges have passed with `held_rst` low and `sup_min_ok` high. It falls at once when `sup_min_ok` falls.
- R5: A read-class opcode is forwarded while `rd_en` is 1, even if `wr_en` is still 0.
- R6: `wr_en` implies `rd_en`. If `sup_min_ok` rises after the write delay has already run out, `wr_en` rises together with `rd_en`.
- R7: `init_clr` is a single-cycle pulse in the first cycle after `held_rst` falls.
- R8: If `sup_inhibit_ok` falls, `held_rst` rises and `rd_en`/`wr_en` fall in the same cycle, and both timers restart from their full delays.
- R9: An opcode strobed while `cs_n` is 1 produces neither pulse.
- R10: The write-class opcodes are 0x06, 0x0A, 0x02, 0xDB, 0xD8, 0x20, 0xC7, 0x01 and 0xE5. Every other opcode value is read-class.
- R11: The verdict for a strobed opcode appears as a one-cycle pulse on the edge after the strobe. `op_accept` and `op_ignored` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asserted asynchronously |
| sup_inhibit_ok | input | 1 | Supply above the write-inhibit threshold |
| sup_min_ok | input | 1 | Supply at or above the minimum operating level |
| cs_n | input | 1 | Chip select, active low |
| op_valid | input | 1 | Decoded opcode strobe |
| op_code | input | 8 | Decoded opcode |
| held_rst | output | 1 | Core held in reset |
| rd_en | output | 1 | Read-class instructions released |
| wr_en | output | 1 | Write-class instructions released |
| init_clr | output | 1 | Pulse that returns status and lock bits to power-up values |
| op_accept | output | 1 | Opcode forwarded (one-cycle pulse) |
| op_ignored | output | 1 | Opcode blocked (one-cycle pulse) |

## Verification
The bench builds the gate with `WR_DLY` = 20 and `RD_DLY` = 6, so the read window opens well before the write window. With these values both orderings fit in a short run. In one, reads are live while writes are still refused. In the other, the minimum-level flag rises only after the write delay has expired, and both enables open on the same edge. The small delays also allow repeated supply drops, restarts and an asynchronous reset inside one run.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int unsigned OP_W = 8;
  typedef logic [OP_W-1:0] opcode_t;

  localparam int unsigned DEF_NUM_WR = 9;
  localparam logic [DEF_NUM_WR*OP_W-1:0] DEF_WR_OPS =
    {8'h06, 8'h0A, 8'h02, 8'hDB, 8'hD8, 8'h20, 8'hC7, 8'h01, 8'hE5};

  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_ACCEPT = 2'd1,
    VERD_IGNORE = 2'd2
  } verdict_t;
endpackage

// File: rtl/fpg_rst_sync.sv
module fpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fpg_delay_timer.sv
module fpg_delay_timer #(
  parameter int unsigned DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int unsigned CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DLY);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)           cnt_d = RELOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R8: a restart request always brings the count back to the full delay
  p_restart_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == RELOAD));
  // R4: once expired, the timer stays expired until restarted
  p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);
endmodule

// File: rtl/fpg_op_class.sv
module fpg_op_class
  import fpg_pkg::*;
#(
  parameter int unsigned NUM_WR = DEF_NUM_WR,
  parameter logic [NUM_WR*OP_W-1:0] WR_OPS = DEF_WR_OPS
) (
  input  opcode_t op_code,
  output logic    is_write
);
  logic [NUM_WR-1:0] hit;

  for (genvar g = 0; g < NUM_WR; g++) begin : g_cmp
    assign hit[g] = (op_code == WR_OPS[g*OP_W +: OP_W]);
  end

  assign is_write = |hit;
endmodule

// File: rtl/flash_pwrup_gate.sv
module flash_pwrup_gate
  import fpg_pkg::*;
#(
  parameter int unsigned WR_DLY = 2000,
  parameter int unsigned RD_DLY = 500,
  parameter int unsigned NUM_WR = DEF_NUM_WR,
  parameter logic [NUM_WR*OP_W-1:0] WR_OPS = DEF_WR_OPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup_inhibit_ok,
  input  logic            sup_min_ok,
  input  logic            cs_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  output logic            held_rst,
  output logic            rd_en,
  output logic            wr_en,
  output logic            init_clr,
  output logic            op_accept,
  output logic            op_ignored
);
  logic     rst_sync_n;
  logic     wr_done, rd_done, is_write;
  logic     held_q;
  verdict_t verd_d, verd_q;

  fpg_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign held_rst = !rst_sync_n || !sup_inhibit_ok;

  fpg_delay_timer #(.DLY(WR_DLY)) u_wr_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (held_rst),
    .done    (wr_done)
  );

  fpg_delay_timer #(.DLY(RD_DLY)) u_rd_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (held_rst || !sup_min_ok),
    .done    (rd_done)
  );

  fpg_op_class #(.NUM_WR(NUM_WR), .WR_OPS(WR_OPS)) u_cls (
    .op_code  (op_code),
    .is_write (is_write)
  );

  assign rd_en = !held_rst && sup_min_ok && rd_done;
  assign wr_en = rd_en && wr_done;

  always_comb begin
    verd_d = VERD_NONE;
    if (!held_rst && op_valid && !cs_n) begin
      if (is_write) verd_d = wr_en ? VERD_ACCEPT : VERD_IGNORE;
      else          verd_d = rd_en ? VERD_ACCEPT : VERD_IGNORE;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      verd_q <= VERD_NONE;
      held_q <= 1'b1;
    end else begin
      verd_q <= verd_d;
      held_q <= held_rst;
    end
  end

  assign op_accept  = (verd_q == VERD_ACCEPT);
  assign op_ignored = (verd_q == VERD_IGNORE);
  assign init_clr   = held_q && !held_rst;

  p_held_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    held_rst |-> (!rd_en && !wr_en));
  p_quiet_when_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    held_rst |=> (!op_accept && !op_ignored));
  p_write_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rd_en);
  p_init_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> !init_clr);
  p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!op_accept && !op_ignored));
  p_verdict_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_accept && op_ignored));
endmodule

// File: tb/sim_flash_pwrup_gate.sv
module sim_flash_pwrup_gate;
  localparam int WR = 20;
  localparam int RD = 6;

  logic clk = 1'b0;
  logic rst_n, inh, minok, cs_n, valid;
  logic [7:0] op;
  logic held, rde, wre, initc, acc, ign;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  flash_pwrup_gate #(.WR_DLY(WR), .RD_DLY(RD)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_inhibit_ok(inh), .sup_min_ok(minok),
    .cs_n(cs_n), .op_valid(valid), .op_code(op),
    .held_rst(held), .rd_en(rde), .wr_en(wre), .init_clr(initc),
    .op_accept(acc), .op_ignored(ign)
  );

  function automatic bit is_wr_op(input logic [7:0] c);
    case (c)
      8'h06, 8'h0A, 8'h02, 8'hDB, 8'hD8, 8'h20, 8'hC7, 8'h01, 8'hE5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_s1, m_s2, m_hd, m_acc, m_ign;
  int m_wc, m_rc;
  bit model_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_hd = 1; m_acc = 0; m_ign = 0; m_wc = 0; m_rc = 0;
    end else begin
      bit h, rn, wn;
      h  = !m_s2 || !inh;
      rn = !h && minok && (m_rc == RD);
      wn = rn && (m_wc == WR);
      m_acc = 0; m_ign = 0;
      if (!h && valid && !cs_n) begin
        if (is_wr_op(op)) begin m_acc = wn; m_ign = !wn; end
        else              begin m_acc = rn; m_ign = !rn; end
      end
      m_wc = h ? 0 : ((m_wc < WR) ? m_wc + 1 : m_wc);
      m_rc = (h || !minok) ? 0 : ((m_rc < RD) ? m_rc + 1 : m_rc);
      m_hd = h;
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit eh, er, ew;
      eh = !rst_n || !m_s2 || !inh;
      er = !eh && minok && (m_rc == RD);
      ew = er && (m_wc == WR);
      chk("R1 held_rst", held, eh);
      chk("R4 rd_en", rde, er);
      chk("R3 wr_en", wre, ew);
      chk("R7 init_clr", initc, rst_n && m_hd && !eh);
      chk("R10 op_accept", acc, rst_n && m_acc);
      chk("R11 op_ignored", ign, rst_n && m_ign);
    end
  end

  task automatic send(input logic [7:0] c, input logic sel_n);
    @(posedge clk); #1;
    valid = 1'b1; op = c; cs_n = sel_n;
    @(posedge clk); #1;
    valid = 1'b0; cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; inh = 0; minok = 0; cs_n = 1; valid = 0; op = 8'h00;
    model_on = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset held", held, 1'b1);
    chk("R1 reset rd", rde, 1'b0);
    chk("R1 reset wr", wre, 1'b0);

    @(posedge clk); #1;
    rst_n = 1; inh = 1; minok = 1; cs_n = 0;
    for (int i = 0; i < 100 && !rde; i++) @(negedge clk);
    chk("R5 window rd", rde, 1'b1);
    chk("R5 window wr", wre, 1'b0);
    send(8'h03, 1'b0);
    chk("R5 read forwarded", acc, 1'b1);
    send(8'h06, 1'b0);
    chk("R3 write ignored", ign, 1'b1);
    chk("R3 write not forwarded", acc, 1'b0);
    send(8'h0B, 1'b0);
    chk("R10 non-listed opcode read-class", acc, 1'b1);
    for (int i = 0; i < 100 && !wre; i++) @(negedge clk);
    send(8'h02, 1'b0);
    chk("R10 program forwarded", acc, 1'b1);
    send(8'hE5, 1'b0);
    chk("R10 lock write forwarded", acc, 1'b1);
    send(8'h03, 1'b1);
    chk("R9 deselected accept", acc, 1'b0);
    chk("R9 deselected ignore", ign, 1'b0);

    @(posedge clk); #1; inh = 0; #1;
    chk("R8 drop held", held, 1'b1);
    chk("R8 drop rd", rde, 1'b0);
    chk("R8 drop wr", wre, 1'b0);
    send(8'h03, 1'b0);
    chk("R2 held no accept", acc, 1'b0);
    chk("R2 held no ignore", ign, 1'b0);

    minok = 0;
    @(posedge clk); #1; inh = 1;
    @(negedge clk);
    chk("R7 init pulse", initc, 1'b1);
    @(negedge clk);
    chk("R7 init single", initc, 1'b0);
    cycles(WR + 5);
    chk("R6 min late rd", rde, 1'b0);
    chk("R6 min late wr", wre, 1'b0);
    send(8'h06, 1'b0);
    chk("R3 ignored without min", ign, 1'b1);
    @(posedge clk); #1; minok = 1;
    repeat (RD - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 one edge short", rde, 1'b0);
    @(negedge clk);
    chk("R4 rd at delay", rde, 1'b1);
    chk("R6 wr together", wre, 1'b1);

    @(posedge clk); #1; minok = 0; #1;
    chk("R4 min drop rd", rde, 1'b0);
    chk("R4 min drop wr", wre, 1'b0);
    chk("R4 min drop not held", held, 1'b0);
    @(posedge clk); #1; minok = 1;
    cycles(RD + 2);
    chk("R8 writes keep running", wre, 1'b1);

    @(posedge clk); #1; inh = 0;
    cycles(2);
    inh = 1;
    cycles(RD + 2);
    chk("R8 rd back", rde, 1'b1);
    chk("R8 wr restarted", wre, 1'b0);

    rst_n = 0; #1;
    chk("R1 async held", held, 1'b1);
    chk("R1 async rd", rde, 1'b0);
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sync stage 1", held, 1'b1);
    @(negedge clk);
    chk("R1 sync stage 2", held, 1'b1);
    @(negedge clk);
    chk("R1 released", held, 1'b0);
    cycles(WR + 3);
    chk("R3 wr after delay", wre, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule